// File: doc/BRIEF.md
# Page Write Buffer with Completion Polling

This block is the write front end of a small byte-wide non-volatile memory model. A synchronous write strobe, qualified by a chip enable and an output enable, delivers one address and one data byte per cycle. Accepted bytes are gathered into a one-page holding buffer of 64 bytes. A per-byte flag records which offsets were written. The page number is taken from the first byte of a load phase and kept until that phase ends.

When no further byte arrives within a programmable gap, the block enters a timed internal write phase and raises `busy`. It stays busy for a fixed number of cycles. At the end of the phase it copies only the flagged bytes into the backing array, then clears the buffer state. Software can poll for completion during the phase. A read of the address of the last loaded byte returns that byte inverted, and true data returns once the phase has finished.

Reads are combinational from `addr` to `rd_data`. The address is `PAGE_SEL_W + 6` bits wide: the upper bits select the page and the low six bits select the byte within it. The backing array is a plain register array that reset sets to the erased value 0xFF.

Top module: `pgwr_front`

## Requirements
- R1: After synchronous reset, `busy` is low and every address reads 0xFF.
- R2: The page number (address bits above bit 5) is taken from the first accepted byte of a load phase. Page bits on later bytes of the same phase are ignored, and those bytes go to the captured page at their own offset (bits 5..0).
- R3: Bytes may be loaded in any offset order. Loading an offset again within the phase replaces its buffered value, so the last value loaded is the one committed.
- R4: `busy` rises exactly `GAP_CYC` clock edges after the edge that accepted the last byte. A byte accepted at or before that edge restarts the count.
- R5: A commit changes only the offsets loaded in that phase. Every other byte of the page, and of the array, keeps its value.
- R6: `busy` stays high for exactly `WRITE_CYC` cycles. The array takes the new bytes on the edge where `busy` falls.
- R7: While `busy` is high, a read of the last loaded byte's address returns the bitwise inverse of that byte on all 8 bits.
- R8: While `busy` is high, a read of any other address returns the array contents from before the commit.
- R9: A strobe is ignored when `out_en` is high or `chip_en` is low. It loads nothing and starts no commit.
- R10: Strobes that arrive while `busy` is high are dropped. No byte is loaded and no later commit follows from them.
- R11: A single accepted byte goes through the same gap-and-commit flow as a one-byte page.
- R12: When a commit finishes, the loaded flags and the page capture clear. The next accepted byte opens a new phase on its own page.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chip_en | input | 1 | Chip enable, active high |
| out_en | input | 1 | Output enable, active high; blocks writes |
| wr_stb | input | 1 | One-cycle byte write strobe |
| addr | input | PAGE_SEL_W+6 | Byte address for writes and reads |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data or polling value for `addr` |
| busy | output | 1 | Internal write phase in progress |

## Verification
A full page is loaded in ascending order. A scattered partial page follows, with overwritten offsets and changing page bits, which shows that unloaded bytes are kept and that the page number does not move. Loads are also spaced exactly one cycle inside the gap, to separate a correct gap restart from an off-by-one expiry. Gated strobes and strobes sent during the write phase must leave the whole array unchanged and start no commit. Polling reads of the last byte and of its neighbours during the phase show the inverted value apart from the old array contents.

// File: rtl/pgwr_pkg.sv
// Shared constants and types for the page write front end.
// Assumes a 64-byte page and byte-wide data throughout.
package pgwr_pkg;
    localparam int OFF_W      = 6;
    localparam int PAGE_BYTES = 1 << OFF_W;
    localparam int DATA_W     = 8;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [OFF_W-1:0]  off_t;
    typedef logic [PAGE_BYTES-1:0] mask_t;
endpackage

// File: rtl/pgwr_page_buf.sv
// Page holding buffer: captures the page number on the first load of a
// phase, stores bytes by offset, records which offsets were loaded and
// remembers the most recent offset. Assumes load and clear never coincide
// (the top blocks loads while a commit is running).
module pgwr_page_buf
    import pgwr_pkg::*;
#(
    parameter int PAGE_SEL_W = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic [PAGE_SEL_W-1:0]         ld_page,
    input  off_t                          ld_off,
    input  byte_t                         ld_data,
    input  logic                          clear,
    output logic [PAGE_SEL_W-1:0]         page_q,
    output logic                          latched,
    output mask_t                         mask,
    output off_t                          last_off,
    output logic [PAGE_BYTES-1:0][DATA_W-1:0] data_q
);

    // Page capture and phase-open flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            latched <= 1'b0;
            page_q  <= '0;
        end else if (load && !latched) begin
            latched <= 1'b1;
            page_q  <= ld_page;
        end
    end

    // Loaded-offset flags and last loaded offset.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            mask     <= '0;
            last_off <= '0;
        end else if (load) begin
            mask[ld_off] <= 1'b1;
            last_off     <= ld_off;
        end
    end

    // Byte storage; a reload of an offset overwrites it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (load) begin
            data_q[ld_off] <= ld_data;
        end
    end

    // R2: the captured page does not move while the phase stays open.
    a_r2_page_held: assert property (@(posedge clk) disable iff (!rst_n)
        (latched && !clear) |=> $stable(page_q));

    // R3: a load always leaves its offset flagged and recorded as last.
    a_r3_load_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clear) |=> (mask[$past(ld_off)] && last_off == $past(ld_off)));

endmodule

// File: rtl/pgwr_gap_timer.sv
// Load-window timer: counts idle cycles while a phase is open and the
// block is not busy; a load restarts the count. Emits a one-cycle expire
// pulse once GAP_CYC edges have passed since the last load.
// Assumes GAP_CYC >= 2.
module pgwr_gap_timer #(
    parameter int GAP_CYC = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic kick,
    output logic expire
);
    localparam int CW = $clog2(GAP_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(GAP_CYC - 1);

    logic [CW-1:0] cnt;

    assign expire = armed && !kick && (cnt == LAST);

    // Idle counter, cleared by a load or while disarmed.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed || kick) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R4: the count never passes the window limit.
    a_r4_gap_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R4: a load leaves the counter at zero on the next cycle.
    a_r4_kick_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (kick && armed) |=> (cnt == '0));

endmodule

// File: rtl/pgwr_commit_seq.sv
// Commit sequencer: on start, holds busy for WRITE_CYC cycles and pulses
// done in the final one. Assumes WRITE_CYC >= 2 and that start never
// arrives while busy.
module pgwr_commit_seq #(
    parameter int WRITE_CYC = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(WRITE_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(WRITE_CYC - 1);

    logic [CW-1:0] cnt;

    assign done = busy && (cnt == LAST);

    // Busy flag and phase cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start && !busy) begin
            busy <= 1'b1;
            cnt  <= '0;
        end else if (done) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (busy) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R6: busy cannot drop before the full phase length.
    a_r6_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R6: the phase counter stays inside its range.
    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

endmodule

// File: rtl/pgwr_front.sv
// Top of the page write front end. Qualifies write strobes, feeds the
// page buffer, runs the gap timer and commit sequencer, holds the backing
// array and forms the read path including completion polling.
// Assumes a synchronous active-low reset; the array resets to 0xFF.
module pgwr_front
    import pgwr_pkg::*;
#(
    parameter int PAGE_SEL_W = 3,
    parameter int GAP_CYC    = 10000,
    parameter int WRITE_CYC  = 500000,
    localparam int ADDR_W    = PAGE_SEL_W + OFF_W,
    localparam int PAGES     = 1 << PAGE_SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_en,
    input  logic              out_en,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    output logic              busy
);

    logic                              wr_acc;
    logic [PAGE_SEL_W-1:0]             page_q;
    logic                              latched;
    mask_t                             mask;
    off_t                              last_off;
    logic [PAGE_BYTES-1:0][DATA_W-1:0] data_q;
    logic                              expire;
    logic                              done;
    logic [PAGE_SEL_W-1:0]             a_page;
    off_t                              a_off;
    logic                              poll_hit;
    logic [PAGE_BYTES-1:0][DATA_W-1:0] mem [PAGES];

    assign a_page = addr[ADDR_W-1:OFF_W];
    assign a_off  = addr[OFF_W-1:0];
    assign wr_acc = wr_stb && chip_en && !out_en && !busy;

    pgwr_page_buf #(.PAGE_SEL_W(PAGE_SEL_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_acc),
        .ld_page  (a_page),
        .ld_off   (a_off),
        .ld_data  (wr_data),
        .clear    (done),
        .page_q   (page_q),
        .latched  (latched),
        .mask     (mask),
        .last_off (last_off),
        .data_q   (data_q)
    );

    pgwr_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .armed  (latched && !busy),
        .kick   (wr_acc),
        .expire (expire)
    );

    pgwr_commit_seq #(.WRITE_CYC(WRITE_CYC)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (expire),
        .busy  (busy),
        .done  (done)
    );

    // Backing array: erased on reset, loaded bytes copied in at done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < PAGES; p++) begin
                mem[p] <= {PAGE_BYTES{8'hFF}};
            end
        end else if (done) begin
            for (int b = 0; b < PAGE_BYTES; b++) begin
                if (mask[b]) begin
                    mem[page_q][b] <= data_q[b];
                end
            end
        end
    end

    // Read path: inverted last byte while busy, array contents otherwise.
    always_comb begin
        poll_hit = busy && (a_page == page_q) && (a_off == last_off);
        if (poll_hit) begin
            rd_data = ~data_q[last_off];
        end else begin
            rd_data = mem[a_page][a_off];
        end
    end

    // R4: a commit only starts with at least one byte loaded.
    a_r4_start_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mask != '0));

    // R12: buffer state is clear once the phase ends.
    a_r12_clear_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (mask == '0 && !latched));

    // R10: the loaded flags do not change during the write phase.
    a_r10_frozen_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(mask));

    // R4: an accepted byte never starts the commit on the next edge.
    a_r4_load_defers: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc |=> !busy);

endmodule

// File: tb/pgwr_front_test.sv
module pgwr_front_test;
    localparam int CLK_PERIOD = 10;
    localparam int PSW   = 3;
    localparam int GAP   = 8;
    localparam int WCYC  = 20;
    localparam int AW    = PSW + 6;
    localparam int NBYTE = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          chip_en = 1'b1;
    logic          out_en = 1'b0;
    logic          wr_stb = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wr_data = '0;
    logic [7:0]    rd_data;
    logic          busy;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [7:0] exp_mem [NBYTE];
    logic [7:0] pend_data [64];
    logic       pend_mask [64];
    int         pend_page = -1;

    pgwr_front #(.PAGE_SEL_W(PSW), .GAP_CYC(GAP), .WRITE_CYC(WCYC)) uut (
        .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .out_en(out_en),
        .wr_stb(wr_stb), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive one strobe; called at a negedge, returns at the next negedge.
    task automatic strobe(input int page, input int off, input int data, input bit accept);
        addr = AW'((page << 6) | off);
        wr_data = 8'(data);
        wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        if (accept) begin
            if (pend_page < 0) pend_page = page;
            pend_mask[off] = 1'b1;
            pend_data[off] = 8'(data);
        end
    endtask

    task automatic apply_model();
        for (int i = 0; i < 64; i++) begin
            if (pend_mask[i]) exp_mem[(pend_page << 6) | i] = pend_data[i];
            pend_mask[i] = 1'b0;
        end
        pend_page = -1;
    endtask

    task automatic read_at(input int a, output int v);
        addr = AW'(a);
        #1;
        v = int'(rd_data);
    endtask

    task automatic sweep(input string req);
        int v;
        for (int a = 0; a < NBYTE; a++) begin
            read_at(a, v);
            check(req, v, int'(exp_mem[a]));
        end
    endtask

    // Wait out window and write phase from the negedge after the last load.
    task automatic finish_commit();
        ticks(GAP + WCYC);
        apply_model();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int v;
        for (int a = 0; a < NBYTE; a++) exp_mem[a] = 8'hFF;
        for (int i = 0; i < 64; i++) pend_mask[i] = 1'b0;
        ticks(3);
        rst_n = 1'b1;
        ticks(1);

        // R1: reset state
        check("R1 busy", int'(busy), 0);
        sweep("R1 erased");

        // Full page in order, with exact window and phase timing (R4, R6)
        for (int i = 0; i < 64; i++) strobe(2, i, (i * 37 + 5) & 255, 1);
        ticks(GAP - 1);
        check("R4 busy before window end", int'(busy), 0);
        ticks(1);
        check("R4 busy at window end", int'(busy), 1);
        read_at((2 << 6) | 10, v);
        check("R8 old data while busy", v, 8'hFF);
        ticks(WCYC - 1);
        check("R6 busy last cycle", int'(busy), 1);
        read_at((2 << 6) | 10, v);
        check("R6 array not yet written", v, 8'hFF);
        ticks(1);
        check("R6 busy fell", int'(busy), 0);
        apply_model();
        sweep("R6 full page commit");

        // Scattered partial page, overwrites, page bits changed (R2, R3, R5, R7)
        for (int i = 0; i < 20; i++) strobe(5, (i * 23) % 64, (i * 11 + 1) & 255, 1);
        strobe(5, 23, 8'h77, 1);
        strobe(1, 46, 8'h99, 1);
        strobe(7, 40, 8'h3C, 1);
        ticks(GAP);
        check("R4 busy partial", int'(busy), 1);
        read_at((5 << 6) | 40, v);
        check("R7 inverted last byte", v, 8'hC3);
        read_at((5 << 6) | 23, v);
        check("R8 other loaded byte old", v, 8'hFF);
        read_at((7 << 6) | 40, v);
        check("R2 other page not polled", v, 8'hFF);
        ticks(WCYC);
        read_at((5 << 6) | 40, v);
        check("R7 true data after", v, 8'h3C);
        read_at((5 << 6) | 23, v);
        check("R3 last value wins", v, 8'h77);
        read_at((1 << 6) | 46, v);
        check("R2 page bits ignored", v, 8'hFF);
        apply_model();
        sweep("R5 only loaded bytes");

        // Gated strobes (R9)
        out_en = 1'b1;
        strobe(3, 4, 8'h12, 0);
        out_en = 1'b0;
        chip_en = 1'b0;
        strobe(3, 5, 8'h34, 0);
        chip_en = 1'b1;
        ticks(GAP + 3);
        check("R9 no commit", int'(busy), 0);
        sweep("R9 array unchanged");

        // Single byte then strobes during busy (R11, R10, R12)
        strobe(0, 0, 8'h11, 1);
        ticks(GAP);
        check("R11 single byte busy", int'(busy), 1);
        strobe(0, 1, 8'h22, 0);
        strobe(6, 2, 8'h33, 0);
        ticks(WCYC - 2);
        check("R11 done", int'(busy), 0);
        apply_model();
        ticks(GAP + 3);
        check("R10 no later commit", int'(busy), 0);
        sweep("R10 dropped strobes");

        // Loads spaced one cycle inside the window (R4, R12 new page)
        strobe(4, 9, 8'hA1, 1);
        for (int k = 0; k < 3; k++) begin
            ticks(GAP - 1);
            check("R4 still loading", int'(busy), 0);
            strobe(4, 10 + k, 8'hB0 + k, 1);
        end
        ticks(GAP - 1);
        check("R4 quiet before end", int'(busy), 0);
        ticks(1);
        check("R4 spaced commit", int'(busy), 1);
        ticks(WCYC);
        apply_model();
        sweep("R12 new phase page");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule